// File: doc/BRIEF.md
# Fixed-Frame Command Packet Codec

This block handles a simple command protocol in which every packet is exactly sixteen bytes long. On the receive side it takes one byte per accepted cycle and tracks the byte's position in the frame. It splits out the count byte, the three-letter ASCII command code and the payload, and it checks the trailing checksum byte against the running sum of everything before it. One cycle after the last byte it reports a command class, the received count and a status code. While the packet is arriving, it presents each valid payload byte with its payload index.

On the transmit side it builds a packet from a count, a command code and up to ten payload bytes, all taken in one cycle. It then sends the sixteen bytes on consecutive cycles. It fills unused payload positions and the pad byte with zero, and it sends the checksum last. Two things are left to other logic: moving bytes over a line, and acting on the decoded commands.

Frame layout, by offset: 0 is the count, 1 to 3 are the command code (first letter first), 4 to 13 are payload bytes 0 to 9, 14 is a pad byte, and 15 is the checksum.

Top module: `pkt_codec`

## Requirements
- R1: A packet is sixteen accepted bytes; cycles with `rx_valid_i` low do not advance the frame position. `res_valid_o` pulses for exactly one cycle, in the cycle after the sixteenth byte is accepted, and the next accepted byte is treated as offset 0.
- R2: The expected checksum is the low 8 bits of the sum of bytes 0 to 14, pad included. If byte 15 differs from it, the status is 1 (bad checksum), whatever the count or code.
- R3: If the checksum matches but the count byte is greater than 10, the status is 2 (bad count).
- R4: `res_cmd_o` gives the class of the received code: "GJR" gives 1 (fiber read) and "GWJ" gives 2 (fiber write). "GWA", "GWB", "GWC" and "GWD" give 3, 4, 5 and 6 (digital outputs A to D). Any other code gives 0.
- R5: If the checksum matches, the count is 10 or less, and the code is not one of the six known codes, the status is 3 (unknown command) and `res_cmd_o` is 0.
- R6: Payload byte k (frame offset 4+k) appears on `pl_byte_o`, with `pl_idx_o` equal to k and `pl_valid_o` high, in the cycle after it is accepted. This happens only when k is less than the count. Payload positions at or beyond the count produce no `pl_valid_o`.
- R7: A packet with a matching checksum, a count of 10 or less and a known code reports status 0 (good). `res_count_o` always carries the received count byte.
- R8: In the cycle after `tx_start_i` is sampled while idle, `tx_valid_o` rises and stays high for sixteen cycles. The bytes sent, in order, are the count, the three code bytes (`tx_id_i[23:16]` first), payload bytes 0 to 9 (`tx_payload_i[8k+7:8k]`, sent as 0x00 when k is not less than the count), a pad byte of 0x00, and the checksum of the fifteen bytes before it.
- R9: `tx_start_i` is ignored while a packet is being sent: it neither changes the bytes in flight nor adds a packet afterwards.
- R10: After reset, `res_valid_o`, `pl_valid_o` and `tx_valid_o` are low and the receive frame position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Receive byte accepted this cycle |
| rx_byte_i | input | 8 | Receive byte |
| res_valid_o | output | 1 | Packet result pulse |
| res_status_o | output | 2 | 0 good, 1 bad checksum, 2 bad count, 3 unknown command |
| res_cmd_o | output | 3 | Decoded command class |
| res_count_o | output | 8 | Received count byte |
| pl_valid_o | output | 1 | Payload byte strobe |
| pl_byte_o | output | 8 | Payload byte |
| pl_idx_o | output | 4 | Payload byte index |
| tx_start_i | input | 1 | Start building a packet |
| tx_count_i | input | 8 | Count for the built packet |
| tx_id_i | input | 24 | Three-letter command code |
| tx_payload_i | input | 80 | Payload bytes, byte k in bits 8k+7:8k |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_byte_o | output | 8 | Transmit byte |

## Verification
The receive path gets one clean packet for each of the six known codes, at counts 0, 3 and 10. These separate the class decode from the payload gating: a count of 0 must produce no payload strobe, and a count of 10 must strobe every payload position. Further packets each trip exactly one check: a corrupted checksum that also carries an unknown code, a count of 11 with a valid sum, and an unknown code with a valid sum. Together they show the fixed priority between the three error statuses. A packet with a non-zero pad and a packet with idle cycles inside it show that the pad is part of the sum and that gaps do not shift offsets. The transmit path sends a short packet and an empty one, and gets a start pulse mid-packet; this shows zero fill, the checksum, and that a start during a send is ignored.

// File: rtl/pkt_codec_pkg.sv
package pkt_codec_pkg;
  localparam int PKT_BYTES = 16;
  localparam int PL_BYTES  = 10;
  localparam int ID_BYTES  = 3;
  localparam int CNT_OFS   = 0;
  localparam int ID_OFS    = 1;
  localparam int PL_OFS    = ID_OFS + ID_BYTES;
  localparam int PAD_OFS   = PL_OFS + PL_BYTES;
  localparam int CS_OFS    = PKT_BYTES - 1;
  localparam int IDX_W     = $clog2(PKT_BYTES);
  localparam int PLI_W     = $clog2(PL_BYTES);

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BAD_SUM = 2'd1,
    ST_BAD_CNT = 2'd2,
    ST_UNKNOWN = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_FRD  = 3'd1,
    CMD_FWR  = 3'd2,
    CMD_DO_A = 3'd3,
    CMD_DO_B = 3'd4,
    CMD_DO_C = 3'd5,
    CMD_DO_D = 3'd6
  } cmd_e;
endpackage

// File: rtl/pkt_cmd_decode.sv
module pkt_cmd_decode
  import pkt_codec_pkg::*;
(
  input  logic [8*ID_BYTES-1:0] id_i,
  output logic [2:0]            cmd_o,
  output logic                  known_o
);
  localparam int N_DO = 4;

  logic [N_DO-1:0] do_hit;

  for (genvar g = 0; g < N_DO; g++) begin : g_do
    assign do_hit[g] = (id_i == {"GW", 8'("A" + g)});
  end

  always_comb begin
    cmd_o = CMD_NONE;
    if (id_i == "GJR") cmd_o = CMD_FRD;
    if (id_i == "GWJ") cmd_o = CMD_FWR;
    for (int k = 0; k < N_DO; k++)
      if (do_hit[k]) cmd_o = 3'(int'(CMD_DO_A) + k);
  end

  assign known_o = (cmd_o != CMD_NONE);
endmodule

// File: rtl/pkt_rx_parser.sv
module pkt_rx_parser
  import pkt_codec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  output logic             res_valid_o,
  output logic [1:0]       res_status_o,
  output logic [2:0]       res_cmd_o,
  output logic [7:0]       res_count_o,
  output logic             pl_valid_o,
  output logic [7:0]       pl_byte_o,
  output logic [PLI_W-1:0] pl_idx_o
);
  logic [IDX_W-1:0]      idx_q;
  logic [7:0]            sum_q;
  logic [7:0]            cnt_q;
  logic [8*ID_BYTES-1:0] id_q;
  logic [2:0]            cmd;
  logic                  known;
  logic                  last, in_id, in_pl;
  logic [IDX_W-1:0]      pl_rel;

  pkt_cmd_decode u_dec (.id_i(id_q), .cmd_o(cmd), .known_o(known));

  assign last   = (idx_q == IDX_W'(CS_OFS));
  assign in_id  = (idx_q >= IDX_W'(ID_OFS)) && (idx_q < IDX_W'(PL_OFS));
  assign in_pl  = (idx_q >= IDX_W'(PL_OFS)) && (idx_q < IDX_W'(PAD_OFS));
  assign pl_rel = idx_q - IDX_W'(PL_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q        <= '0;
      sum_q        <= '0;
      cnt_q        <= '0;
      id_q         <= '0;
      res_valid_o  <= 1'b0;
      res_status_o <= ST_OK;
      res_cmd_o    <= CMD_NONE;
      res_count_o  <= '0;
      pl_valid_o   <= 1'b0;
      pl_byte_o    <= '0;
      pl_idx_o     <= '0;
    end else begin
      res_valid_o <= 1'b0;
      pl_valid_o  <= 1'b0;
      if (valid_i) begin
        if (last) begin
          idx_q       <= '0;
          sum_q       <= '0;
          res_valid_o <= 1'b1;
          res_cmd_o   <= cmd;
          res_count_o <= cnt_q;
          // fixed priority: checksum, then count, then code
          if (byte_i != sum_q)             res_status_o <= ST_BAD_SUM;
          else if (cnt_q > 8'(PL_BYTES))   res_status_o <= ST_BAD_CNT;
          else if (!known)                 res_status_o <= ST_UNKNOWN;
          else                             res_status_o <= ST_OK;
        end else begin
          idx_q <= idx_q + 1'b1;
          sum_q <= sum_q + byte_i;
        end
        if (idx_q == IDX_W'(CNT_OFS)) cnt_q <= byte_i;
        if (in_id) id_q <= {id_q[8*(ID_BYTES-1)-1:0], byte_i};
        if (in_pl && (8'(pl_rel) < cnt_q)) begin
          pl_valid_o <= 1'b1;
          pl_byte_o  <= byte_i;
          pl_idx_o   <= pl_rel[PLI_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/pkt_tx_builder.sv
module pkt_tx_builder
  import pkt_codec_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [7:0]            count_i,
  input  logic [8*ID_BYTES-1:0] id_i,
  input  logic [8*PL_BYTES-1:0] payload_i,
  output logic                  valid_o,
  output logic [7:0]            byte_o
);
  logic                  busy_q;
  logic [IDX_W-1:0]      idx_q;
  logic [7:0]            sum_q;
  logic [7:0]            cnt_q;
  logic [8*ID_BYTES-1:0] id_q;
  logic [8*PL_BYTES-1:0] pl_q;
  logic [7:0]            cur;

  always_comb begin
    cur = '0;  // pad and unused payload stay zero
    if (idx_q == IDX_W'(CNT_OFS)) cur = cnt_q;
    for (int k = 0; k < ID_BYTES; k++)
      if (idx_q == IDX_W'(ID_OFS + k)) cur = id_q[8*(ID_BYTES-1-k) +: 8];
    for (int k = 0; k < PL_BYTES; k++)
      if (idx_q == IDX_W'(PL_OFS + k) && 8'(k) < cnt_q) cur = pl_q[8*k +: 8];
    if (idx_q == IDX_W'(CS_OFS)) cur = sum_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sum_q  <= '0;
      cnt_q  <= '0;
      id_q   <= '0;
      pl_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        sum_q  <= '0;
        cnt_q  <= count_i;
        id_q   <= id_i;
        pl_q   <= payload_i;
      end
    end else begin
      sum_q <= sum_q + cur;
      if (idx_q == IDX_W'(CS_OFS)) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign valid_o = busy_q;
  assign byte_o  = cur;
endmodule

// File: rtl/pkt_codec.sv
module pkt_codec
  import pkt_codec_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  output logic        res_valid_o,
  output logic [1:0]  res_status_o,
  output logic [2:0]  res_cmd_o,
  output logic [7:0]  res_count_o,
  output logic        pl_valid_o,
  output logic [7:0]  pl_byte_o,
  output logic [3:0]  pl_idx_o,
  input  logic        tx_start_i,
  input  logic [7:0]  tx_count_i,
  input  logic [23:0] tx_id_i,
  input  logic [79:0] tx_payload_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_byte_o
);
  pkt_rx_parser u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (rx_valid_i),
    .byte_i       (rx_byte_i),
    .res_valid_o  (res_valid_o),
    .res_status_o (res_status_o),
    .res_cmd_o    (res_cmd_o),
    .res_count_o  (res_count_o),
    .pl_valid_o   (pl_valid_o),
    .pl_byte_o    (pl_byte_o),
    .pl_idx_o     (pl_idx_o)
  );

  pkt_tx_builder u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tx_start_i),
    .count_i   (tx_count_i),
    .id_i      (tx_id_i),
    .payload_i (tx_payload_i),
    .valid_o   (tx_valid_o),
    .byte_o    (tx_byte_o)
  );
endmodule

// File: rtl/pkt_codec_chk.sv
module pkt_codec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_valid_i,
  input logic [7:0]  rx_byte_i,
  input logic        res_valid_o,
  input logic [1:0]  res_status_o,
  input logic [2:0]  res_cmd_o,
  input logic [7:0]  res_count_o,
  input logic        pl_valid_o,
  input logic [7:0]  pl_byte_o,
  input logic [3:0]  pl_idx_o,
  input logic        tx_start_i,
  input logic [7:0]  tx_count_i,
  input logic [23:0] tx_id_i,
  input logic [79:0] tx_payload_i,
  input logic        tx_valid_o,
  input logic [7:0]  tx_byte_o
);
  logic [4:0] tx_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tx_run_q <= '0;
    else if (tx_valid_o) tx_run_q <= tx_run_q + 1'b1;
    else                 tx_run_q <= '0;
  end

  p_res_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  p_cnt_bad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_count_o > 8'd10) |-> res_status_o != 2'd0);

  p_unknown_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_status_o == 2'd3) |-> res_cmd_o == 3'd0);

  p_pl_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_valid_o |-> (pl_idx_o < 4'd10 && !res_valid_o));

  p_ok_known_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_status_o == 2'd0) |-> (res_cmd_o != 3'd0 && res_count_o <= 8'd10));

  p_tx_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_i && !tx_valid_o) |=> (tx_valid_o && tx_byte_o == $past(tx_count_i)));

  p_tx_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_run_q < 5'd16);

  p_tx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_run_q < 5'd15) |=> tx_valid_o);
endmodule

bind pkt_codec pkt_codec_chk u_chk (.*);

// File: tb/pkt_codec_tb.sv
module pkt_codec_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        res_valid_o;
  logic [1:0]  res_status_o;
  logic [2:0]  res_cmd_o;
  logic [7:0]  res_count_o;
  logic        pl_valid_o;
  logic [7:0]  pl_byte_o;
  logic [3:0]  pl_idx_o;
  logic        tx_start_i = 1'b0;
  logic [7:0]  tx_count_i = '0;
  logic [23:0] tx_id_i = '0;
  logic [79:0] tx_payload_i = '0;
  logic        tx_valid_o;
  logic [7:0]  tx_byte_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [12:0] res_q[$];  // {status, cmd, count}
  logic [11:0] pl_q[$];   // {idx, byte}
  logic [7:0]  tx_q[$];

  always #10 clk_i = ~clk_i;

  pkt_codec u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cmd(input logic [23:0] id);
    if (id == "GJR") return 3'd1;
    if (id == "GWJ") return 3'd2;
    if (id == "GWA") return 3'd3;
    if (id == "GWB") return 3'd4;
    if (id == "GWC") return 3'd5;
    if (id == "GWD") return 3'd6;
    return 3'd0;
  endfunction

  task automatic send_pkt(input logic [7:0] cnt, input logic [23:0] id, input logic [79:0] pl,
                          input logic [7:0] pad, input bit corrupt, input int gap_at);
    logic [7:0] b[16];
    logic [7:0] sum;
    logic [1:0] st;
    b[0] = cnt;
    for (int k = 0; k < 3; k++) b[1+k] = id[8*(2-k) +: 8];
    for (int k = 0; k < 10; k++) b[4+k] = pl[8*k +: 8];
    b[14] = pad;
    sum = '0;
    for (int k = 0; k < 15; k++) sum = sum + b[k];
    b[15] = corrupt ? (sum ^ 8'h5a) : sum;
    if (corrupt)                 st = 2'd1;
    else if (cnt > 8'd10)        st = 2'd2;
    else if (exp_cmd(id) == 0)   st = 2'd3;
    else                         st = 2'd0;
    res_q.push_back({st, exp_cmd(id), cnt});
    for (int k = 0; k < 10; k++)
      if (k < int'(cnt)) pl_q.push_back({4'(k), b[4+k]});
    for (int i = 0; i < 16; i++) begin
      if (i == gap_at) begin
        @(negedge clk_i) rx_valid_i = 1'b0;
        @(negedge clk_i);
      end else begin
        @(negedge clk_i);
      end
      rx_valid_i = 1'b1;
      rx_byte_i  = b[i];
    end
    @(negedge clk_i) rx_valid_i = 1'b0;
    rx_byte_i = 8'hee;
  endtask

  task automatic build_pkt(input logic [7:0] cnt, input logic [23:0] id, input logic [79:0] pl);
    logic [7:0] b[16];
    logic [7:0] sum;
    b[0] = cnt;
    for (int k = 0; k < 3; k++) b[1+k] = id[8*(2-k) +: 8];
    for (int k = 0; k < 10; k++) b[4+k] = (k < int'(cnt)) ? pl[8*k +: 8] : 8'h00;
    b[14] = 8'h00;
    sum = '0;
    for (int k = 0; k < 15; k++) sum = sum + b[k];
    b[15] = sum;
    for (int k = 0; k < 16; k++) tx_q.push_back(b[k]);
    @(negedge clk_i);
    tx_start_i   = 1'b1;
    tx_count_i   = cnt;
    tx_id_i      = id;
    tx_payload_i = pl;
    @(negedge clk_i) tx_start_i = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni && res_valid_o) begin
        if (res_q.size() == 0) chk(1'b0, "R1 unexpected result", 32'(res_status_o), 32'hffff);
        else begin
          logic [12:0] e;
          e = res_q.pop_front();
          chk(res_status_o == e[12:11], "R2/R3/R5/R7 status", 32'(res_status_o), 32'(e[12:11]));
          chk(res_cmd_o == e[10:8], "R4 command class", 32'(res_cmd_o), 32'(e[10:8]));
          chk(res_count_o == e[7:0], "R7 count", 32'(res_count_o), 32'(e[7:0]));
        end
      end
      if (rst_ni && pl_valid_o) begin
        if (pl_q.size() == 0) chk(1'b0, "R6 unexpected payload", {pl_idx_o, pl_byte_o}, 32'hffff);
        else begin
          logic [11:0] e;
          e = pl_q.pop_front();
          chk({pl_idx_o, pl_byte_o} == e, "R6 payload", 32'({pl_idx_o, pl_byte_o}), 32'(e));
        end
      end
      if (rst_ni && tx_valid_o) begin
        if (tx_q.size() == 0) chk(1'b0, "R9 unexpected tx byte", 32'(tx_byte_o), 32'hffff);
        else begin
          logic [7:0] e;
          e = tx_q.pop_front();
          chk(tx_byte_o == e, "R8 tx byte", 32'(tx_byte_o), 32'(e));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk(!res_valid_o && !pl_valid_o && !tx_valid_o, "R10 reset outputs low",
        32'({res_valid_o, pl_valid_o, tx_valid_o}), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R4/R6/R7: each known code, counts 0, 3 and 10
    send_pkt(8'd3,  "GJR", 80'h0a_09_08_07_06_05_04_03_02_01, 8'h00, 0, -1);
    send_pkt(8'd10, "GWJ", 80'hf0_e1_d2_c3_b4_a5_96_87_78_69, 8'h00, 0, -1);
    send_pkt(8'd0,  "GWA", 80'h11_22_33_44_55_66_77_88_99_aa, 8'h00, 0, -1);
    send_pkt(8'd1,  "GWB", 80'h0000_0000_0000_0000_00ff,      8'h00, 0, -1);
    send_pkt(8'd2,  "GWC", 80'h0000_0000_0000_0000_5a5a,      8'h00, 0, -1);
    send_pkt(8'd4,  "GWD", 80'h0000_0000_0000_dead_beef,      8'h00, 0, -1);
    // R2: corrupted checksum wins over unknown code
    send_pkt(8'd2,  "XYZ", 80'h0000_0000_0000_0000_1234,      8'h00, 1, -1);
    // R3: count 11 with matching sum
    send_pkt(8'd11, "GJR", 80'h01_02_03_04_05_06_07_08_09_0a, 8'h00, 0, -1);
    // R5: unknown code with good sum
    send_pkt(8'd1,  "GWE", 80'h0000_0000_0000_0000_0042,      8'h00, 0, -1);
    // R2: pad byte counts toward the sum
    send_pkt(8'd2,  "GWJ", 80'h0000_0000_0000_0000_7788,      8'h3c, 0, -1);
    // R1: idle gaps inside a packet
    send_pkt(8'd5,  "GWD", 80'h0000_0000_0055_4433_2211,      8'h00, 0, 2);
    send_pkt(8'd3,  "GJR", 80'h0000_0000_0000_00c0_b0a0,      8'h00, 0, 15);
    repeat (4) @(negedge clk_i);

    // R8: build packets
    build_pkt(8'd3, "GWJ", 80'hff_ff_ff_ff_ff_ff_ff_13_12_11);
    repeat (5) @(negedge clk_i);
    // R9: start while busy is ignored
    tx_start_i = 1'b1; tx_count_i = 8'd9; tx_id_i = "GWA"; tx_payload_i = '1;
    @(negedge clk_i) tx_start_i = 1'b0;
    repeat (14) @(negedge clk_i);
    build_pkt(8'd0, "GJR", 80'hab_ab_ab_ab_ab_ab_ab_ab_ab_ab);
    repeat (24) @(negedge clk_i);

    chk(res_q.size() == 0, "R1 all results seen", 32'(res_q.size()), 32'd0);
    chk(pl_q.size() == 0, "R6 all payload seen", 32'(pl_q.size()), 32'd0);
    chk(tx_q.size() == 0 && !tx_valid_o, "R9 tx drained", 32'(tx_q.size()), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule